// File: doc/BRIEF.md
# Bank-Mapping Address Translator with Region Select

This block sits beside a processor core that issues 16-bit logical addresses. It widens each address to a 21-bit physical one by means of eight 8-bit bank registers. The top three logical bits pick one bank register, and that register's byte replaces them as the upper part of the physical address. The lower 13 bits pass through unchanged, so each register governs one 8KB window of logical space.

The core loads the bank registers through a write port and reads them back through a read port. Both ports take an 8-bit one-hot selection mask in place of a binary index. The translated address also drives a fixed region decoder. This decoder pulls one of seven active-low enables low when a valid access falls in the work RAM range or in one of the 1KB peripheral windows at the top of the physical map.

Top module: `bank_mmu`

## Requirements
- R1: After reset every bank register holds 0x00, so every logical address translates to physical 0x00 in bits [20:13] with the logical bits [12:0] below.
- R2: `phys_addr` equals {bank[log_addr[15:13]], log_addr[12:0]} combinationally from the current register contents. For example, logical 0x3F13 with bank 1 = 0xF8 gives 0x1F1F13.
- R3: When `map_we` is high at a rising clock edge, every bank n whose mask bit `map_sel[n]` is 1 loads `map_wdata`. A bank whose bit is 0 keeps its value.
- R4: A write with several mask bits set loads the same byte into all selected banks in one cycle. A write with an all-zero mask changes no bank.
- R5: `map_rdata` returns the bank chosen by the lowest set bit of `map_sel`, and returns 0x00 when `map_sel` is zero.
- R6: In a cycle where a bank is both written and read, or both written and used for translation, `map_rdata` and `phys_addr` show the old contents. The new value appears from the following cycle.
- R7: When `acc_valid` is high and physical bits [20:13] are 0xFF, the 1KB window given by bits [12:10] pulls one enable low. The mapping is: 0 -> ce_n[0] (video display controller), 1 -> ce_n[1] (colour encoder), 2 -> ce_n[2] (sound generator), 3 -> ce_n[3] (timer), 4 -> ce_n[4] (I/O port), 5 -> ce_n[5] (interrupt control).
- R8: Windows 6 and 7 of segment 0xFF (physical 0x1FF800-0x1FFFFF) are reserved and leave all enables high.
- R9: When `acc_valid` is high and physical bits [20:13] are 0xF8 to 0xFB, ce_n[6] (work RAM) is low. Every segment other than 0xF8-0xFB and 0xFF leaves all enables high.
- R10: When `acc_valid` is low, all enables are high. At no time is more than one enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_we | input | 1 | Bank register write strobe |
| map_sel | input | 8 | One-hot bank selection mask for read and write |
| map_wdata | input | 8 | Byte to load into selected banks |
| map_rdata | output | 8 | Contents of lowest selected bank |
| acc_valid | input | 1 | Access strobe enabling region decode |
| log_addr | input | 16 | Logical address from the core |
| phys_addr | output | 21 | Translated physical address |
| ce_n | output | 7 | Active-low region enables, bit order per R7 and R9 |

## Verification
A register write and a translation through that same register can occur in the same cycle, and so can a write and a read-back of that register. The bench provokes this by driving `map_we` with a mask bit while `log_addr` points into that bank's window and `map_sel` selects it for reading. Before the edge it expects `phys_addr` and `map_rdata` to carry the old byte, and after the edge the new one. This exposes any forwarding of the write data, as well as any stale path that misses the update.

// File: rtl/bank_mmu_pkg.sv
package bank_mmu_pkg;
    localparam int NUM_BANKS = 8;
    localparam int BANK_W    = 8;
    localparam int OFF_W     = 13;
    localparam int LOG_W     = OFF_W + $clog2(NUM_BANKS);
    localparam int PHYS_W    = OFF_W + BANK_W;
    localparam int IDX_W     = $clog2(NUM_BANKS);

    // region decode
    localparam int WIN_W        = 10;
    localparam int WIN_IDX_W    = OFF_W - WIN_W;
    localparam logic [BANK_W-1:0] IO_SEG     = 8'hFF;
    localparam logic [BANK_W-1:0] RAM_SEG_LO = 8'hF8;
    localparam logic [BANK_W-1:0] RAM_SEG_HI = 8'hFB;

    localparam int CE_VDC  = 0;
    localparam int CE_VCE  = 1;
    localparam int CE_SND  = 2;
    localparam int CE_TMR  = 3;
    localparam int CE_PORT = 4;
    localparam int CE_IRQ  = 5;
    localparam int CE_RAM  = 6;
    localparam int NUM_CE  = 7;
    localparam int NUM_IO_WIN = 6;

    typedef logic [BANK_W-1:0] bank_t;

    typedef struct packed {
        bank_t [NUM_BANKS-1:0] bank;
    } bank_state_t;
endpackage

// File: rtl/mmu_bank_file.sv
module mmu_bank_file
    import bank_mmu_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [NUM_BANKS-1:0]          sel,
    input  bank_t                         wdata,
    output bank_t                         rdata,
    output bank_t [NUM_BANKS-1:0]         banks
);
    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (we && sel[i]) st_d.bank[i] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // lowest selected bit wins: scan from the top so lower bits overwrite
    always_comb begin
        rdata = '0;
        for (int i = NUM_BANKS-1; i >= 0; i--) begin
            if (sel[i]) rdata = st_q.bank[i];
        end
    end

    assign banks = st_q.bank;

    generate
        for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chk
            // R3
            bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (we && sel[g]) |=> (banks[g] == $past(wdata)));
            // R4
            bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(we && sel[g]) |=> $stable(banks[g]));
        end
    endgenerate
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
    import bank_mmu_pkg::*;
(
    input  bank_t [NUM_BANKS-1:0] banks,
    input  logic [LOG_W-1:0]      log_addr,
    output logic [PHYS_W-1:0]     phys_addr
);
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx       = log_addr[LOG_W-1:OFF_W];
        phys_addr = {banks[idx], log_addr[OFF_W-1:0]};
    end
endmodule

// File: rtl/mmu_cs_decode.sv
module mmu_cs_decode
    import bank_mmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [PHYS_W-1:0] phys_addr,
    output logic [NUM_CE-1:0] ce_n
);
    bank_t                seg;
    logic [WIN_IDX_W-1:0] win;
    logic [NUM_CE-1:0]    hit;

    always_comb begin
        seg = phys_addr[PHYS_W-1:OFF_W];
        win = phys_addr[OFF_W-1:WIN_W];
        hit = '0;
        if (valid) begin
            if (seg == IO_SEG) begin
                for (int w = 0; w < NUM_IO_WIN; w++) begin
                    if (int'(win) == w) hit[w] = 1'b1;
                end
            end
            if (seg >= RAM_SEG_LO && seg <= RAM_SEG_HI) hit[CE_RAM] = 1'b1;
        end
        ce_n = ~hit;
    end

    // R10
    ce_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (&ce_n));
    // R10
    ce_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ce_n));
endmodule

// File: rtl/bank_mmu.sv
module bank_mmu
    import bank_mmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_we,
    input  logic [7:0]        map_sel,
    input  logic [7:0]        map_wdata,
    output logic [7:0]        map_rdata,
    input  logic              acc_valid,
    input  logic [15:0]       log_addr,
    output logic [20:0]       phys_addr,
    output logic [6:0]        ce_n
);
    bank_t [NUM_BANKS-1:0] banks;

    mmu_bank_file u_banks (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (map_we),
        .sel   (map_sel),
        .wdata (map_wdata),
        .rdata (map_rdata),
        .banks (banks)
    );

    mmu_xlate u_xlate (
        .banks     (banks),
        .log_addr  (log_addr),
        .phys_addr (phys_addr)
    );

    mmu_cs_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (acc_valid),
        .phys_addr (phys_addr),
        .ce_n      (ce_n)
    );

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[12:0] == log_addr[12:0]);
endmodule

// File: tb/bank_mmu_tb.sv
module bank_mmu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_we = 1'b0;
    logic [7:0]  map_sel = '0;
    logic [7:0]  map_wdata = '0;
    logic [7:0]  map_rdata;
    logic        acc_valid = 1'b0;
    logic [15:0] log_addr = '0;
    logic [20:0] phys_addr;
    logic [6:0]  ce_n;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [8];

    always #4 clk = ~clk;

    bank_mmu u_dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_ce(input logic v, input logic [20:0] pa);
        logic [6:0] h = '0;
        if (v) begin
            if (pa[20:13] == 8'hFF && pa[12:10] < 3'd6) h[pa[12:10]] = 1'b1;
            if (pa[20:13] >= 8'hF8 && pa[20:13] <= 8'hFB) h[6] = 1'b1;
        end
        return ~h;
    endfunction

    task automatic do_write(input logic [7:0] mask, input logic [7:0] d);
        @(negedge clk);
        map_we = 1'b1; map_sel = mask; map_wdata = d;
        @(negedge clk);
        map_we = 1'b0; map_sel = '0;
        for (int i = 0; i < 8; i++) if (mask[i]) model[i] = d;
    endtask

    task automatic t_reset();
        for (int b = 0; b < 8; b++) begin
            log_addr = {b[2:0], 13'h0ABC};
            map_sel = 8'(1 << b);
            #1;
            check("R1 phys", 32'(phys_addr), {11'd0, 8'h00, 13'h0ABC});
            check("R1 rdata", 32'(map_rdata), 32'h0);
        end
        map_sel = '0;
    endtask

    task automatic t_translate();
        do_write(8'h02, 8'hF8);
        log_addr = 16'h3F13; #1;
        check("R2 example", 32'(phys_addr), 32'h1F1F13);
        do_write(8'h80, 8'h5A);
        log_addr = 16'hFFF6; #1;
        check("R2 top bank", 32'(phys_addr), {11'd0, 8'h5A, 13'h1FF6});
        check("R3 neighbour kept", 32'(model[1]), 32'hF8);
        log_addr = 16'h2000; #1;
        check("R3 bank1 unaffected", 32'(phys_addr), {11'd0, 8'hF8, 13'h0});
    endtask

    task automatic t_multi_zero();
        do_write(8'h2C, 8'h33);
        for (int b = 0; b < 8; b++) begin
            log_addr = {b[2:0], 13'h0001}; #1;
            check("R4 multi", 32'(phys_addr), {11'd0, model[b], 13'h1});
        end
        do_write(8'h00, 8'hEE);
        for (int b = 0; b < 8; b++) begin
            map_sel = 8'(1 << b); #1;
            check("R4 zero mask", 32'(map_rdata), 32'(model[b]));
        end
        map_sel = '0;
    endtask

    task automatic t_read_prio();
        do_write(8'h10, 8'h44);
        map_sel = 8'hF0; #1;
        check("R5 lowest bit", 32'(map_rdata), 32'h44);
        map_sel = 8'hA8; #1;
        check("R5 lowest bit b3", 32'(map_rdata), 32'(model[3]));
        map_sel = 8'h00; #1;
        check("R5 zero mask", 32'(map_rdata), 32'h0);
    endtask

    task automatic t_same_cycle();
        logic [7:0] old = model[1];
        @(negedge clk);
        map_we = 1'b1; map_sel = 8'h02; map_wdata = 8'hC3; log_addr = 16'h2005;
        #1;
        check("R6 rdata old", 32'(map_rdata), 32'(old));
        check("R6 phys old", 32'(phys_addr), {11'd0, old, 13'h0005});
        @(negedge clk);
        map_we = 1'b0; model[1] = 8'hC3; #1;
        check("R6 rdata new", 32'(map_rdata), 32'hC3);
        check("R6 phys new", 32'(phys_addr), {11'd0, 8'hC3, 13'h0005});
        map_sel = '0;
    endtask

    task automatic t_io();
        do_write(8'h80, 8'hFF);
        acc_valid = 1'b1;
        for (int w = 0; w < 8; w++) begin
            log_addr = 16'hE000 | 16'(w << 10) | 16'h0123; #1;
            if (w < 6) check("R7 io window", 32'(ce_n), 32'(exp_ce(1'b1, phys_addr)));
            else       check("R8 reserved", 32'(ce_n), 32'h7F);
        end
        log_addr = 16'hE7FF; #1;
        check("R7 vce top edge", 32'(ce_n), 32'h7D);
        acc_valid = 1'b0; #1;
        check("R10 invalid io", 32'(ce_n), 32'h7F);
    endtask

    task automatic t_ram();
        logic [7:0] segs [6] = '{8'hF7, 8'hF8, 8'hF9, 8'hFA, 8'hFB, 8'hFC};
        acc_valid = 1'b1;
        foreach (segs[k]) begin
            do_write(8'h08, segs[k]);
            log_addr = 16'h6010; #1;
            check("R9 ram", 32'(ce_n), (segs[k] >= 8'hF8 && segs[k] <= 8'hFB) ? 32'h3F : 32'h7F);
        end
        do_write(8'h08, 8'h00); log_addr = 16'h7FFF; #1;
        check("R9 low seg none", 32'(ce_n), 32'h7F);
        do_write(8'h08, 8'hF8);
        acc_valid = 1'b0; #1;
        check("R10 invalid ram", 32'(ce_n), 32'h7F);
    endtask

    bit done = 0;
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        #20 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_translate();
        t_multi_zero();
        t_read_prio();
        t_same_cycle();
        t_io();
        t_ram();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule